// File: doc/BRIEF.md
# Realigning Instruction Fetch Queue

This block sits between the instruction memory port and the decode stage. It accepts 32-bit memory words, one at a time, tags each with the word address it was fetched from, and holds them in a small queue. On the read side it presents exactly one instruction per cycle. The instruction is either a 16-bit compressed one or a full 32-bit one, starting at any half-word. A 32-bit instruction that straddles two words is stitched together from the upper half of one word and the lower half of the next.

When nothing is held, an arriving word is visible on the output in the same cycle. If the decode stage accepts it, the word never occupies storage. A clear input flushes all held words and loads a new start address. Bit 1 of that address selects which half of the first word begins the stream, and bit 0 is ignored. Compressed instructions leave the block in their raw 16-bit form, so later stages can report the original encoding.

Top module: `fetch_realign_fifo`

## Requirements
- R1: The queue holds up to DEPTH words (default 3). `in_ready_o` is low while DEPTH words are held and no held word is released in that cycle; otherwise it is high, except during clear.
- R2: `out_addr_o` equals the recorded word address of the instruction's first half, with bit 1 set to that half's offset within the word and bit 0 always 0.
- R3: With no word held, a valid input word drives the output combinationally in the same cycle.
- R4: An instruction is compressed when bits [1:0] of its first half are not 2'b11. For a compressed instruction, `out_compressed_o` is 1 and `out_instr_o` is the raw 16-bit half in bits [15:0], with bits [31:16] zero.
- R5: After an accepted instruction, the next one starts 2 bytes further on if the accepted one was compressed, and 4 bytes further on otherwise.
- R6: A 32-bit instruction places its first half in bits [15:0] and its second half in bits [31:16]. When it starts at offset 2 in a word, it is valid only once the following word is also present.
- R7: `out_err_o` is the OR of the error flags of every word that supplies part of the instruction.
- R8: While `clear_i` is high, `out_valid_o` and `in_ready_o` are low and the input word is dropped. After the clear, the queue is empty and the stream restarts at `start_addr_i`.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the instruction, address and error flag stay unchanged into the next cycle, unless a clear intervenes.
- R10: After reset the queue is empty, `out_valid_o` is 0, `in_ready_o` is 1, and the stream starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Flush held words and restart at the start address |
| start_addr_i | input | AW | Byte address of the first instruction after a clear |
| in_valid_i | input | 1 | Input word present |
| in_data_i | input | 32 | Fetched memory word |
| in_err_i | input | 1 | Fetch error for this word |
| in_ready_o | output | 1 | Input word is taken this cycle |
| out_valid_o | output | 1 | Instruction present on the output |
| out_ready_i | input | 1 | Decode stage accepts the instruction |
| out_instr_o | output | 32 | Instruction bits, compressed ones zero-extended |
| out_addr_o | output | AW | Byte address of the instruction |
| out_err_o | output | 1 | Error flag of the instruction's source words |
| out_compressed_o | output | 1 | Instruction is 16-bit |

## Verification
Several properties are checked on every cycle. The queue never overflows or releases a word it lacks. A full queue with no release refuses input. A stalled output is frozen. Accepted instructions step the address by 2 or 4, and a clear leaves nothing valid unless a new word arrives. The assembled bits, the joining of halves across words, error merging, and the restart offset after a clear at an odd half-word are covered only by the bench. It runs a half-word queue model alongside the design under mixes of compressed and full-width code, starved and back-pressured traffic, and random clears.

// File: rtl/fetch_realign_pkg.sv
package fetch_realign_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned HALF_W = 16;

   typedef struct packed {
      logic [WORD_W-1:0] data;
      logic              err;
   } fetch_word_t;

   // A half-word opens a compressed instruction unless its two low bits are set
   function automatic logic is_short(input logic [HALF_W-1:0] h);
      return h[1:0] != 2'b11;
   endfunction

endpackage

// File: rtl/fetch_realign_store.sv
module fetch_realign_store
   import fetch_realign_pkg::*;
#(
   parameter int unsigned DEPTH = 3,
   parameter int unsigned AW    = 32,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              push_i,
   input  fetch_word_t       push_word_i,
   input  logic [AW-1:2]     push_addr_i,
   input  logic              pop_i,
   output fetch_word_t       head_word_o,
   output logic [AW-1:2]     head_addr_o,
   output fetch_word_t       next_word_o,
   output logic [CW-1:0]     count_o
);

   fetch_word_t         word_q [DEPTH];
   logic [AW-1:2]       addr_q [DEPTH];
   logic [PW-1:0]       rd_q, wr_q, rd_nxt, wr_nxt;
   logic [CW-1:0]       cnt_q;

   generate
      if ((2 ** PW) == DEPTH) begin : g_pow2_wrap
         assign rd_nxt = rd_q + 1'b1;
         assign wr_nxt = wr_q + 1'b1;
      end else begin : g_cmp_wrap
         assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         assign wr_nxt = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (push_i) begin
         word_q[wr_q] <= push_word_i;
         addr_q[wr_q] <= push_addr_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (clear_i) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wr_q <= wr_nxt;
         if (pop_i)  rd_q <= rd_nxt;
         cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
      end
   end

   assign head_word_o = word_q[rd_q];
   assign head_addr_o = addr_q[rd_q];
   assign next_word_o = word_q[rd_nxt];
   assign count_o     = cnt_q;

   // R1: a write with no release never lands on a full queue
   a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !pop_i && !clear_i) |-> (count_o != CW'(DEPTH)));

   // R3: releasing from an empty queue only happens for a word fed through
   a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && !clear_i) |-> (count_o != '0 || push_i));

endmodule

// File: rtl/fetch_realign_align.sv
module fetch_realign_align
   import fetch_realign_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 2
) (
   input  logic              half_i,
   input  logic              clear_i,
   input  logic [CW-1:0]     count_i,
   input  fetch_word_t       head_word_i,
   input  logic [AW-1:2]     head_addr_i,
   input  fetch_word_t       next_word_i,
   input  logic              in_valid_i,
   input  fetch_word_t       in_word_i,
   input  logic [AW-1:2]     in_addr_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] instr_o,
   output logic [AW-1:0]     addr_o,
   output logic              err_o,
   output logic              short_o,
   output logic              pop_o,
   output logic              half_next_o
);

   logic              have0, have1, v0, v1, need2, fire;
   fetch_word_t       w0, w1;
   logic [AW-1:2]     a0;
   logic [HALF_W-1:0] lo, hi;

   always_comb begin
      have0 = count_i != '0;
      have1 = count_i > CW'(1);
      // First two words of the stream, with the input word standing in
      // for whichever slot storage cannot fill yet
      w0 = have0 ? head_word_i : in_word_i;
      a0 = have0 ? head_addr_i : in_addr_i;
      v0 = have0 | in_valid_i;
      w1 = have1 ? next_word_i : in_word_i;
      v1 = have1 | (have0 & in_valid_i);

      lo    = half_i ? w0.data[WORD_W-1:HALF_W] : w0.data[HALF_W-1:0];
      hi    = half_i ? w1.data[HALF_W-1:0]      : w0.data[WORD_W-1:HALF_W];
      short_o = is_short(lo);
      need2 = half_i & ~short_o;

      valid_o = ~clear_i & v0 & (~need2 | v1);
      err_o   = w0.err | (need2 & w1.err);
      instr_o = short_o ? {{HALF_W{1'b0}}, lo} : {hi, lo};
      addr_o  = {a0, half_i, 1'b0};

      // A word leaves once its last half has been consumed
      fire        = valid_o & ready_i;
      pop_o       = fire & (half_i | ~short_o);
      half_next_o = fire ? (half_i ^ short_o) : half_i;
   end

endmodule

// File: rtl/fetch_realign_fifo.sv
module fetch_realign_fifo
   import fetch_realign_pkg::*;
#(
   parameter int unsigned DEPTH = 3,
   parameter int unsigned AW    = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clear_i,
   input  logic [AW-1:0] start_addr_i,
   input  logic          in_valid_i,
   input  logic [31:0]   in_data_i,
   input  logic          in_err_i,
   output logic          in_ready_o,
   output logic          out_valid_o,
   input  logic          out_ready_i,
   output logic [31:0]   out_instr_o,
   output logic [AW-1:0] out_addr_o,
   output logic          out_err_o,
   output logic          out_compressed_o
);

   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fetch_realign_fifo: DEPTH must be at least 2");
      end
      if (AW < 3) begin : g_bad_aw
         $error("fetch_realign_fifo: AW must be at least 3");
      end
   endgenerate

   fetch_word_t      in_word, head_word, next_word;
   logic [AW-1:2]    wa_q, head_addr;
   logic [CW-1:0]    count;
   logic             half_q, half_next, pop, push;

   assign in_word    = '{data: in_data_i, err: in_err_i};
   assign in_ready_o = ~clear_i & ((count != CW'(DEPTH)) | pop);
   assign push       = in_valid_i & in_ready_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wa_q   <= '0;
         half_q <= 1'b0;
      end else if (clear_i) begin
         wa_q   <= start_addr_i[AW-1:2];
         half_q <= start_addr_i[1];
      end else begin
         if (push) wa_q <= wa_q + 1'b1;
         half_q <= half_next;
      end
   end

   fetch_realign_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (clear_i),
      .push_i      (push),
      .push_word_i (in_word),
      .push_addr_i (wa_q),
      .pop_i       (pop),
      .head_word_o (head_word),
      .head_addr_o (head_addr),
      .next_word_o (next_word),
      .count_o     (count)
   );

   fetch_realign_align #(.AW(AW), .CW(CW)) u_align (
      .half_i      (half_q),
      .clear_i     (clear_i),
      .count_i     (count),
      .head_word_i (head_word),
      .head_addr_i (head_addr),
      .next_word_i (next_word),
      .in_valid_i  (in_valid_i),
      .in_word_i   (in_word),
      .in_addr_i   (wa_q),
      .ready_i     (out_ready_i),
      .valid_o     (out_valid_o),
      .instr_o     (out_instr_o),
      .addr_o      (out_addr_o),
      .err_o       (out_err_o),
      .short_o     (out_compressed_o),
      .pop_o       (pop),
      .half_next_o (half_next)
   );

   // R1: full queue with nothing leaving refuses the input word
   a_r1_full_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count == CW'(DEPTH) && !pop) |-> !in_ready_o);

   // R3: an aligned word arriving at an empty queue is presented at once
   a_r3_feedthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && count == '0 && !clear_i && !half_q) |-> out_valid_o);

   // R5: consecutive instructions are contiguous in the address space
   a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && out_ready_i) |=> (clear_i || !out_valid_o ||
         out_addr_o == $past(out_addr_o) + ($past(out_compressed_o) ? AW'(2) : AW'(4))));

   // R8: after a clear only a freshly arriving word can make the output valid
   a_r8_clear_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (!out_valid_o || in_valid_i));

   // R9: a refused instruction is held unchanged
   a_r9_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_ready_i && !clear_i) |=> (clear_i ||
         (out_valid_o && $stable(out_instr_o) && $stable(out_addr_o) && $stable(out_err_o))));

endmodule

// File: tb/fetch_realign_fifo_bench.sv
module fetch_realign_fifo_bench;

   localparam int DEPTH = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        clear;
   logic [31:0] start_addr;
   logic        in_valid;
   logic [31:0] in_data;
   logic        in_err;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready;
   logic [31:0] out_instr;
   logic [31:0] out_addr;
   logic        out_err;
   logic        out_cmp;

   always #4 clk = ~clk;

   fetch_realign_fifo #(.DEPTH(DEPTH), .AW(32)) u_fetch_realign_fifo (
      .clk_i            (clk),
      .rst_ni           (rst_n),
      .clear_i          (clear),
      .start_addr_i     (start_addr),
      .in_valid_i       (in_valid),
      .in_data_i        (in_data),
      .in_err_i         (in_err),
      .in_ready_o       (in_ready),
      .out_valid_o      (out_valid),
      .out_ready_i      (out_ready),
      .out_instr_o      (out_instr),
      .out_addr_o       (out_addr),
      .out_err_o        (out_err),
      .out_compressed_o (out_cmp)
   );

   typedef struct {
      logic [15:0] h;
      logic        e;
      logic [31:0] a;
      int          id;
   } hw_t;

   hw_t         q[$];
   int          next_id = 0;
   logic [31:0] waddr = '0;
   bit          skip = 1'b0;

   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   bit          prev_fire = 1'b0;
   logic [31:0] prev_addr = '0;
   logic [31:0] prev_step = '0;
   bit          prev_stall = 1'b0;
   logic [31:0] prev_instr = '0;

   task automatic chk(string req, string what, bit ok, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] gen_half(int pct_short);
      logic [15:0] r = 16'($urandom);
      if (int'($urandom_range(99)) < pct_short) r[1:0] = 2'($urandom_range(2));
      else r[1:0] = 2'b11;
      return r;
   endfunction

   function automatic void add_word(ref hw_t dst[$], input logic [31:0] d, input logic e,
                                    input logic [31:0] wa, input bit skp, input int id);
      if (!skp) dst.push_back('{h: d[15:0], e: e, a: wa, id: id});
      dst.push_back('{h: d[31:16], e: e, a: wa + 32'd2, id: id});
   endfunction

   task automatic step(int pshort, int pvalid, int pready, int pclr, int perr);
      hw_t         v[$];
      bit          exp_valid, exp_ready, exp_cmp, exp_err, fire, freed;
      logic [31:0] exp_instr, exp_addr;
      int          n, cnt;
      string       vtag;
      @(negedge clk);
      clear      = int'($urandom_range(999)) < pclr;
      start_addr = 32'($urandom) & 32'hFFFF_FFFE;
      in_valid   = int'($urandom_range(99)) < pvalid;
      in_data    = {gen_half(pshort), gen_half(pshort)};
      in_err     = int'($urandom_range(99)) < perr;
      out_ready  = int'($urandom_range(99)) < pready;
      #1;
      cnt = (q.size() == 0) ? 0 : (q[$].id - q[0].id + 1);
      v = q;
      if (in_valid) add_word(v, in_data, in_err, waddr, skip, next_id);
      exp_valid = 1'b0; exp_cmp = 1'b0; exp_err = 1'b0; n = 0;
      exp_instr = '0; exp_addr = '0;
      if (v.size() > 0) begin
         exp_addr = v[0].a;
         if (v[0].h[1:0] != 2'b11) begin
            exp_valid = 1'b1; exp_cmp = 1'b1; n = 1;
            exp_instr = {16'h0, v[0].h}; exp_err = v[0].e;
         end else if (v.size() > 1) begin
            exp_valid = 1'b1; n = 2;
            exp_instr = {v[1].h, v[0].h}; exp_err = v[0].e | v[1].e;
         end
      end
      if (clear) exp_valid = 1'b0;
      fire  = exp_valid && out_ready;
      freed = fire && (v.size() == n || v[n].id != v[0].id);
      exp_ready = !clear && (cnt < DEPTH || freed);

      vtag = clear ? "R8" : (cnt == 0 ? "R3" : "R6");
      chk(clear ? "R8" : "R1", "in_ready", in_ready === exp_ready, 32'(in_ready), 32'(exp_ready));
      chk(vtag, "out_valid", out_valid === exp_valid, 32'(out_valid), 32'(exp_valid));
      if (exp_valid && out_valid) begin
         chk(exp_cmp ? "R4" : "R6", "out_instr", out_instr === exp_instr, out_instr, exp_instr);
         chk("R2", "out_addr", out_addr === exp_addr, out_addr, exp_addr);
         chk("R7", "out_err", out_err === exp_err, 32'(out_err), 32'(exp_err));
         chk("R4", "out_compressed", out_cmp === exp_cmp, 32'(out_cmp), 32'(exp_cmp));
         if (prev_fire)
            chk("R5", "addr step", out_addr === prev_addr + prev_step, out_addr, prev_addr + prev_step);
      end
      if (prev_stall && !clear)
         chk("R9", "held instr", out_valid && out_instr === prev_instr, out_instr, prev_instr);

      prev_fire  = fire;
      prev_addr  = exp_addr;
      prev_step  = exp_cmp ? 32'd2 : 32'd4;
      prev_stall = out_valid && !out_ready && !clear;
      prev_instr = out_instr;

      if (clear) begin
         q.delete();
         skip  = start_addr[1];
         waddr = {start_addr[31:2], 2'b00};
         prev_fire = 1'b0;
      end else begin
         if (in_valid && exp_ready) begin
            add_word(q, in_data, in_err, waddr, skip, next_id);
            next_id++;
            waddr = waddr + 32'd4;
            skip  = 1'b0;
         end
         if (fire) repeat (n) void'(q.pop_front());
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; clear = 1'b0; start_addr = '0; in_valid = 1'b0;
      in_data = '0; in_err = 1'b0; out_ready = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: empty after reset, ready for input
      chk("R10", "reset out_valid", out_valid === 1'b0, 32'(out_valid), 32'd0);
      chk("R10", "reset in_ready", in_ready === 1'b1, 32'(in_ready), 32'd1);
      // R10: first aligned word with no clear starts at address 0
      step(0, 100, 0, 0, 0);
      chk("R10", "first addr", out_addr === 32'd0, out_addr, 32'd0);
      // R1: back-pressure fills the queue
      for (int i = 0; i < 200; i++) step(50, 90, 10, 0, 0);
      // R8: clear to a random start, then mixed traffic with errors
      step(50, 100, 50, 1000, 0);
      for (int i = 0; i < 1500; i++) step(50, 60, 60, 10, 5);
      // R4: dense compressed code
      for (int i = 0; i < 500; i++) step(100, 70, 70, 5, 5);
      // R6: full-width code, many odd starts after clears
      for (int i = 0; i < 500; i++) step(0, 70, 70, 20, 5);
      // R3: starved input, output mostly fed through
      for (int i = 0; i < 500; i++) step(40, 20, 90, 5, 5);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule